// File: doc/BRIEF.md
# DMA Request Source Router

This block sits in front of a DMA controller and decides which peripheral request line drives each channel's request input. Up to 64 peripheral request lines come in on one vector. Every channel has a one-byte routing setting that either blocks the channel or picks one of those lines. The chosen line is registered once and then drives the channel's request output.

The channels are split into two equal banks, and each bank has its own configuration registers. Software picks a bank and a byte offset within it. Channel `c` therefore lives in bank `c / (NUM_CH/2)` at offset `c % (NUM_CH/2)`. Each routing byte can be written and read back through one byte-wide port. The reset input is asserted asynchronously and is released in step with the clock.

Top module: `dreq_src_mux`

## Requirements
- R1: A routing byte holds the enable in bit 7 and the source index in bits 5:0.
- R2: A channel whose enable bit is 0 drives its request output low, whatever the source inputs do. Writing 0x00 blocks the channel.
- R3: Channels-per-bank is NUM_CH/2. A write or read addressed to bank `b`, offset `o` reaches channel `b*NUM_CH/2 + o`.
- R4: After reset every routing byte reads 0x00 and every request output is low.
- R5: An enabled channel's request output equals the selected source input as sampled at the previous clock edge. This is exactly one register stage.
- R6: Bit 6 is reserved. It reads 0, and writing 1 to it has no effect on routing.
- R7: Reading an address returns the last byte written there, with bit 6 cleared. The new value is visible in the cycle after the write edge.
- R8: If several enabled channels select the same source, every one of them forwards that source's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the addressed routing byte |
| cfg_mux | input | 1 | Bank select (0 = lower channel half, 1 = upper) |
| cfg_off | input | OFF_W | Byte offset within the selected bank |
| cfg_wdata | input | 8 | Routing byte to write |
| cfg_rdata | output | 8 | Routing byte at the current address (combinational) |
| src_req | input | NUM_SRC | Peripheral request lines |
| ch_req | output | NUM_CH | Per-channel request outputs |

## Verification
Two situations are the hardest to reach from the ports. The first is one source feeding channels in both banks at once. The second is a channel being blocked in the same cycle that its selected source is active. The stimulus reaches the first by writing the same index at the same offset in both banks. It reaches the second by clearing the enable bit while driving every source line high. A long phase then mixes random writes with random source patterns, and a cycle-level model of the byte table and one-cycle output register is compared on every clock.

// File: rtl/dreq_mux_pkg.sv
package dreq_mux_pkg;

  localparam int NUM_BANKS  = 2;
  localparam int SEL_W      = 6;
  localparam int SRC_SPACE  = 1 << SEL_W;
  localparam int EN_BIT     = 7;
  localparam int RSVD_BIT   = 6;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } route_cfg_t;

  function automatic route_cfg_t byte_to_cfg(input logic [7:0] b);
    route_cfg_t r;
    r.en  = b[EN_BIT];
    r.sel = b[SEL_W-1:0];
    return r;
  endfunction

  function automatic logic [7:0] cfg_to_byte(input route_cfg_t r);
    return {r.en, 1'b0, r.sel};
  endfunction

endpackage

// File: rtl/dreq_cfg_bank.sv
module dreq_cfg_bank
  import dreq_mux_pkg::*;
#(
  parameter int CPM   = 8,
  parameter int OFF_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [OFF_W-1:0]       off,
  input  logic [7:0]             wr_data,
  output logic [7:0]             rd_data,
  output route_cfg_t [CPM-1:0]   cfg_o
);

  route_cfg_t [CPM-1:0] cfg_q;
  route_cfg_t [CPM-1:0] cfg_d;
  logic       [CPM-1:0] hit;

  for (genvar i = 0; i < CPM; i++) begin : g_dec
    assign hit[i] = wr_en && (off == OFF_W'(i));
  end

  always_comb begin
    cfg_d = cfg_q;
    for (int i = 0; i < CPM; i++) begin
      if (hit[i]) cfg_d[i] = byte_to_cfg(wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < CPM; i++) begin
      if (off == OFF_W'(i)) rd_data = cfg_to_byte(cfg_q[i]);
    end
  end

  assign cfg_o = cfg_q;

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RSVD_BIT] == 1'b0);

endmodule

// File: rtl/dreq_route_lane.sv
module dreq_route_lane
  import dreq_mux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  route_cfg_t           cfg,
  input  logic [SRC_SPACE-1:0] src_ext,
  output logic                 req_o
);

  logic req_d;
  logic req_q;

  always_comb begin
    req_d = cfg.en & src_ext[cfg.sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/dreq_src_mux.sv
module dreq_src_mux
  import dreq_mux_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_SRC = 64,
  localparam int CPM    = NUM_CH / NUM_BANKS,
  localparam int OFF_W  = (CPM > 1) ? $clog2(CPM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_mux,
  input  logic [OFF_W-1:0]   cfg_off,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic [NUM_CH-1:0]  ch_req
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_i_n = rst_pipe[1];

  // sources beyond NUM_SRC read as idle
  logic [SRC_SPACE-1:0] src_ext;
  assign src_ext = SRC_SPACE'(src_req);

  route_cfg_t [NUM_BANKS-1:0][CPM-1:0] bank_cfg;
  logic       [NUM_BANKS-1:0][7:0]     bank_rd;
  route_cfg_t [NUM_CH-1:0]             lane_cfg;

  for (genvar m = 0; m < NUM_BANKS; m++) begin : g_bank
    dreq_cfg_bank #(
      .CPM   (CPM),
      .OFF_W (OFF_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_en   (cfg_we && (cfg_mux == 1'(m))),
      .off     (cfg_off),
      .wr_data (cfg_wdata),
      .rd_data (bank_rd[m]),
      .cfg_o   (bank_cfg[m])
    );
  end

  assign cfg_rdata = bank_rd[cfg_mux];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    assign lane_cfg[c] = bank_cfg[c / CPM][c % CPM];

    dreq_route_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .cfg     (lane_cfg[c]),
      .src_ext (src_ext),
      .req_o   (ch_req[c])
    );

    // R2
    blocked_low_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
      !lane_cfg[c].en |=> !ch_req[c]);

    // R5
    route_follow_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
      lane_cfg[c].en |=> ch_req[c] == $past(src_ext[lane_cfg[c].sel]));
  end

  // R7
  readback_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    cfg_we ##1 ($stable(cfg_mux) && $stable(cfg_off))
      |-> cfg_rdata == ($past(cfg_wdata) & 8'hBF));

endmodule

// File: tb/sim_dreq_src_mux.sv
module sim_dreq_src_mux;

  localparam int NUM_CH  = 16;
  localparam int NUM_SRC = 64;
  localparam int CPM     = NUM_CH / 2;
  localparam int OFF_W   = 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_we;
  logic               cfg_mux;
  logic [OFF_W-1:0]   cfg_off;
  logic [7:0]         cfg_wdata;
  logic [7:0]         cfg_rdata;
  logic [NUM_SRC-1:0] src_req;
  logic [NUM_CH-1:0]  ch_req;

  always #4 clk = ~clk;

  dreq_src_mux #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mux(cfg_mux),
    .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_req(src_req), .ch_req(ch_req)
  );

  int    n_run  = 0;
  int    n_fail = 0;
  string tag    = "R4";
  bit    cmp_on = 1'b0;
  bit    done   = 1'b0;

  // behavioural reference
  logic [7:0]        m_cfg [NUM_CH];
  logic [NUM_CH-1:0] m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) m_cfg[i] = 8'h00;
      m_out = '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        m_out[c] = m_cfg[c][7] ? src_req[m_cfg[c][5:0]] : 1'b0;
      if (cfg_we) m_cfg[int'(cfg_mux) * CPM + int'(cfg_off)] = cfg_wdata & 8'hBF;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk({tag, " ch_req"}, 32'(ch_req), 32'(m_out));
      chk({tag, " rdata"}, 32'(cfg_rdata),
          32'(m_cfg[int'(cfg_mux) * CPM + int'(cfg_off)]));
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic b, input logic [OFF_W-1:0] o, input logic [7:0] d);
    cfg_mux = b; cfg_off = o; cfg_wdata = d; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic at_neg();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mux = 1'b0; cfg_off = '0;
    cfg_wdata = 8'h00; src_req = '1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) step();

    // R4: reset state over every address
    at_neg();
    chk("R4 outputs", 32'(ch_req), 32'h0);
    for (int b = 0; b < 2; b++) begin
      for (int o = 0; o < CPM; o++) begin
        cfg_mux = 1'(b); cfg_off = OFF_W'(o);
        #1 chk("R4 byte", 32'(cfg_rdata), 32'h0);
      end
    end
    src_req = '0;
    step();
    cmp_on = 1'b1;

    // R1 R3 R5 R7: bank 0 offset 2 -> channel 2, source 5
    tag = "R5";
    wr(1'b0, 3'd2, 8'h85);
    at_neg(); chk("R7 readback", 32'(cfg_rdata), 32'h85);
    step();
    src_req = 64'(1) << 5;
    step(); at_neg();
    chk("R5 R3 channel 2 follows source 5", 32'(ch_req), 32'h0004);
    step();
    src_req = '0;
    step(); at_neg();
    chk("R5 release", 32'(ch_req), 32'h0);
    step();

    // R8 R3: bank 1 offset 2 -> channel 10, same source
    tag = "R8";
    wr(1'b1, 3'd2, 8'h85);
    src_req = 64'(1) << 5;
    step(); at_neg();
    chk("R8 shared source", 32'(ch_req), 32'h0404);
    step();

    // R6 R1: reserved bit written as one, source 63
    tag = "R6";
    wr(1'b1, 3'd7, 8'hFF);
    at_neg(); chk("R6 reserved reads zero", 32'(cfg_rdata), 32'hBF);
    step();
    src_req = 64'(1) << 63;
    step(); at_neg();
    chk("R1 R6 source 63 on channel 15", 32'(ch_req), 32'h8000);
    step();

    // R2: blocked channels stay low with every source active
    tag = "R2";
    src_req = '1;
    wr(1'b0, 3'd2, 8'h05);
    step(); at_neg();
    chk("R2 enable clear", 32'(ch_req), 32'h8400);
    step();
    wr(1'b1, 3'd2, 8'h00);
    step(); at_neg();
    chk("R2 zero byte", 32'(ch_req), 32'h8000);
    step();

    // mixed random phase
    tag = "R1 R3 R5 R7 R8";
    for (int k = 0; k < 3000; k++) begin
      src_req = {$urandom, $urandom};
      cfg_mux = 1'($urandom);
      cfg_off = OFF_W'($urandom);
      cfg_wdata = 8'($urandom);
      if (($urandom % 4) == 0) cfg_wdata[5:0] = 6'($urandom % 4);
      cfg_we = (($urandom % 3) == 0);
      step();
    end
    cfg_we = 1'b0;
    step();

    cmp_on = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule